// File: doc/BRIEF.md
# Registered Command Buffer with Delayed Parity Check

This block sits on a memory command/address path. On every rising clock edge it registers a 28-bit command/address word and drives it back out. The parity bit that protects a word does not arrive with it: it comes one clock later. The block therefore keeps the parity of the word it captured and compares it with the parity input on the next edge. A mismatch pulls an active-low error flag low. The flag then stays low for a fixed number of clock cycles so that a slow controller can see it.

Two active-low chip selects gate the check. A word captured while neither select is asserted is not checked. When both selects are deasserted and the gating enable is high, the block is in a low-power state. In that state the output register holds its value. An error flag that is already low stays low for the whole low-power interval and for the normal hold time after it. The reset input forces the flag high at once and clears the internal state on the next clock edge.

Top module: `regbuf_parity_chk`

## Requirements
- R1: Outside low-power mode, `dout` takes the value of `din` at each rising edge. While `rst_n` is low at an edge, `dout` becomes 0.
- R2: A word is captured when `sel0_n` or `sel1_n` is low at an edge. At the next edge, if the XOR of all bits of that word and `parity_in` is 1 (an odd total), `err_n` goes low after that edge.
- R3: If the captured word's bit count plus `parity_in` is even, no error is raised and `err_n` stays high.
- R4: If both `sel0_n` and `sel1_n` are high at an edge, the word on `din` is not checked. `parity_in` at the following edge then has no effect on `err_n`.
- R5: Once `err_n` goes low, it stays low for exactly HOLD_CYC (2) clock cycles and then returns high, provided no new error and no low-power mode occurs in that time.
- R6: A new error detected while `err_n` is already low restarts the hold, so `err_n` stays low for HOLD_CYC cycles counted from the newest error.
- R7: Low-power mode is when `sel0_n`, `sel1_n` and `gate_en` are all high at an edge. In that mode `dout` keeps its previous value.
- R8: While `err_n` is low, each low-power edge reloads the hold. `err_n` therefore stays low through low-power mode and for HOLD_CYC cycles after the last low-power edge. An error on the word captured just before low-power mode is still reported.
- R9: While `rst_n` is low, `err_n` is high without waiting for a clock edge. Reset clears the held parity and the pending-check state, so no error is raised at the first edge after reset is released, whatever `parity_in` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; also masks `err_n` high at once |
| din | input | 28 | Command/address word |
| parity_in | input | 1 | Parity for the word sampled one edge earlier |
| sel0_n | input | 1 | Active-low chip select 0 |
| sel1_n | input | 1 | Active-low chip select 1 |
| gate_en | input | 1 | Allows low-power mode when both selects are high |
| dout | output | 28 | Registered word |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The bench builds the block with its default parameters: a 28-bit word split into 8-bit parity lanes and a 2-cycle error hold. With a 2-cycle hold, errors that arrive back to back inside the hold window and errors stretched across low-power mode both occur within a few cycles of random stimulus, so restart and extension are exercised often. The uneven last lane (4 bits) makes the lane-split parity tree handle a partial slice. Random chip-select, gating and parity-corruption patterns run after directed sequences for reset release, the hold count, hold restart and low-power extension.

// File: rtl/regbuf_pkg.sv
// Shared definitions for the registered command buffer.
// Assumes: consumers pass widths as parameters; nothing here holds state.
package regbuf_pkg;

    // Operating mode decoded from the chip selects and the gating enable.
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,   // at least one select asserted: capture and check
        MODE_IDLE = 2'd1,   // both selects high, gating off: load, no check
        MODE_LPM  = 2'd2    // both selects high, gating on: hold everything
    } bufmode_t;

    // Number of parity lanes needed to cover a word.
    function automatic int lane_count(input int data_w, input int lane_w);
        return (data_w + lane_w - 1) / lane_w;
    endfunction

endpackage

// File: rtl/regbuf_mode_dec.sv
// Mode decoder: maps the two active-low chip selects and the gating enable
// onto one of three operating modes.
// Assumes: inputs are synchronous to the clock of the consumer.
module regbuf_mode_dec
    import regbuf_pkg::*;
(
    input  logic     sel0_n,
    input  logic     sel1_n,
    input  logic     gate_en,
    output bufmode_t mode
);

    // Decode: any asserted select means run; otherwise gating picks idle or low-power.
    always_comb begin
        if (!sel0_n || !sel1_n) begin
            mode = MODE_RUN;
        end else if (gate_en) begin
            mode = MODE_LPM;
        end else begin
            mode = MODE_IDLE;
        end
    end

endmodule

// File: rtl/regbuf_capture.sv
// Capture stage: registers the word lane by lane and keeps the parity of the
// last checked word, plus a flag saying a check is due on the next edge.
// Assumes: DATA_W >= 1, LANE_W >= 1; the last lane may be narrower than LANE_W.
module regbuf_capture
    import regbuf_pkg::*;
#(
    parameter int DATA_W = 28,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  bufmode_t          mode,
    output logic [DATA_W-1:0] dout,
    output logic              word_par,
    output logic              chk_due
);

    localparam int LANES = lane_count(DATA_W, LANE_W);

    logic [LANES-1:0] lane_par;
    logic             load_en;
    logic             capture;

    // Load enable: the output register loads in every mode except low-power.
    assign load_en = (mode != MODE_LPM);
    // Capture: only words seen with a select asserted are checked.
    assign capture = (mode == MODE_RUN);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        localparam int HI = ((LO + LANE_W) > DATA_W) ? (DATA_W - 1) : (LO + LANE_W - 1);

        // Lane parity: XOR of this slice of the incoming word.
        always_comb begin
            lane_par[g] = ^din[HI:LO];
        end

        // Lane register: loads the slice unless low-power mode holds it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dout[HI:LO] <= '0;
            end else if (load_en) begin
                dout[HI:LO] <= din[HI:LO];
            end
        end
    end

    // Parity pipeline: keeps the parity of the captured word for the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_par <= 1'b0;
            chk_due  <= 1'b0;
        end else begin
            chk_due <= capture;
            if (capture) begin
                word_par <= ^lane_par;
            end
        end
    end

endmodule

// File: rtl/regbuf_err_hold.sv
// Error hold: compares the held word parity with the late parity input and
// keeps the error flag low for HOLD_CYC cycles, reloading on new errors and
// on every low-power edge while the flag is low.
// Assumes: HOLD_CYC >= 1.
module regbuf_err_hold #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_due,
    input  logic word_par,
    input  logic parity_in,
    input  logic lpm,
    output logic ok_q
);

    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             mismatch;

    // Mismatch: a due check whose word and parity give an odd total.
    assign mismatch = chk_due && (word_par ^ parity_in);

    // Flag and hold counter: set on error, stretched by low-power, counted down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q     <= 1'b1;
            hold_cnt <= '0;
        end else if (mismatch) begin
            ok_q     <= 1'b0;
            hold_cnt <= RELOAD;
        end else if (!ok_q) begin
            if (lpm) begin
                hold_cnt <= RELOAD;
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end else begin
                ok_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/regbuf_parity_chk.sv
// Top: registered command buffer with a parity check one cycle behind the data.
// Assumes: parity_in belongs to the word sampled on the previous edge; rst_n
// is synchronous for state but masks the error output without a clock.
module regbuf_parity_chk
    import regbuf_pkg::*;
#(
    parameter int DATA_W   = 28,
    parameter int LANE_W   = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              parity_in,
    input  logic              sel0_n,
    input  logic              sel1_n,
    input  logic              gate_en,
    output logic [DATA_W-1:0] dout,
    output logic              err_n
);

    bufmode_t mode;
    logic     word_par;
    logic     chk_due;
    logic     ok_q;

    regbuf_mode_dec u_mode (
        .sel0_n  (sel0_n),
        .sel1_n  (sel1_n),
        .gate_en (gate_en),
        .mode    (mode)
    );

    regbuf_capture #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .mode     (mode),
        .dout     (dout),
        .word_par (word_par),
        .chk_due  (chk_due)
    );

    regbuf_err_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_due   (chk_due),
        .word_par  (word_par),
        .parity_in (parity_in),
        .lpm       (mode == MODE_LPM),
        .ok_q      (ok_q)
    );

    // Output mask: reset drives the flag high without waiting for an edge.
    assign err_n = ok_q | ~rst_n;

endmodule

// File: rtl/regbuf_parity_chk_sva.sv
// Property checker for the registered command buffer, bound to the top.
// Assumes: sees only the top-level ports.
module regbuf_parity_chk_sva #(
    parameter int DATA_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic              sel0_n,
    input logic              sel1_n,
    input logic              gate_en,
    input logic [DATA_W-1:0] dout,
    input logic              err_n
);

    logic lpm_in;
    assign lpm_in = sel0_n && sel1_n && gate_en;

    // R9
    always_comb begin
        if (!rst_n) begin
            rst_mask_chk: assert (err_n);
        end
    end

    // R1
    out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lpm_in |=> (dout == $past(din)));

    // R7
    lpm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_in |=> $stable(dout));

    // R5
    err_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);

    // R4
    no_sel_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel0_n && sel1_n) && sel0_n && sel1_n && err_n) |=> err_n);

endmodule

bind regbuf_parity_chk regbuf_parity_chk_sva #(.DATA_W(DATA_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .sel0_n  (sel0_n),
    .sel1_n  (sel1_n),
    .gate_en (gate_en),
    .dout    (dout),
    .err_n   (err_n)
);

// File: tb/tb_regbuf_parity_chk.sv
module tb_regbuf_parity_chk;

    localparam int DATA_W   = 28;
    localparam int HOLD_CYC = 2;
    localparam int CLK_PER  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              parity_in = 1'b0;
    logic              sel0_n = 1'b1;
    logic              sel1_n = 1'b1;
    logic              gate_en = 1'b0;
    logic [DATA_W-1:0] dout;
    logic              err_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Model state
    logic [DATA_W-1:0] m_dout = '0;
    logic              m_par  = 1'b0;
    logic              m_due  = 1'b0;
    logic              m_ok   = 1'b1;
    int                m_cnt  = 0;
    bit                m_lpm  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    regbuf_parity_chk #(.DATA_W(DATA_W), .LANE_W(8), .HOLD_CYC(HOLD_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .parity_in(parity_in),
        .sel0_n(sel0_n), .sel1_n(sel1_n), .gate_en(gate_en),
        .dout(dout), .err_n(err_n)
    );

    function automatic bit odd_total(input logic [DATA_W-1:0] w, input logic p);
        return (^w) ^ p;
    endfunction

    function automatic bit is_lpm(input logic s0, input logic s1, input logic g);
        return s0 && s1 && g;
    endfunction

    task automatic check1(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s err_n actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic checkw(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s dout actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update for one edge using the inputs applied for that edge.
    task automatic model_edge();
        bit err;
        m_lpm = is_lpm(sel0_n, sel1_n, gate_en);
        if (!rst_n) begin
            m_dout = '0; m_par = 1'b0; m_due = 1'b0; m_ok = 1'b1; m_cnt = 0;
        end else begin
            err = m_due && odd_total({{(DATA_W-1){1'b0}}, m_par}, parity_in);
            if (err) begin
                m_ok = 1'b0; m_cnt = HOLD_CYC - 1;
            end else if (!m_ok) begin
                if (m_lpm) m_cnt = HOLD_CYC - 1;
                else if (m_cnt > 0) m_cnt--;
                else m_ok = 1'b1;
            end
            m_due = !(sel0_n && sel1_n);
            if (m_due) m_par = ^din;
            if (!m_lpm) m_dout = din;
        end
    endtask

    task automatic step(input logic r, input logic s0, input logic s1, input logic g,
                        input logic [DATA_W-1:0] w, input logic p, input string tag);
        @(negedge clk);
        rst_n = r; sel0_n = s0; sel1_n = s1; gate_en = g; din = w; parity_in = p;
        @(posedge clk);
        #1;
        model_edge();
        checkw(m_lpm ? "R7" : "R1", dout, m_dout);
        check1(tag, err_n, m_ok);
    endtask

    initial begin
        logic [DATA_W-1:0] w;
        void'($urandom(32'd4242));
        // R9: reset state
        step(0, 0, 0, 0, 28'hABCDEF1, 1, "R9");
        step(0, 0, 1, 1, 28'h1234567, 0, "R9");
        checkw("R1", dout, '0);
        // R9: first edge after release, bogus parity must not flag
        step(1, 0, 1, 0, 28'h0000001, 1, "R9");
        // R3: odd word + parity 1 -> even total, no error; capture even word
        step(1, 1, 0, 0, 28'h0000003, 1, "R3");
        // R2: even word 0x3 with parity 1 -> error
        step(1, 1, 1, 0, 28'h0000000, 1, "R2");
        check1("R2", err_n, 1'b0);
        // R5: hold two cycles then release
        step(1, 1, 1, 0, 28'h0000000, 0, "R5");
        check1("R5", err_n, 1'b0);
        step(1, 1, 1, 0, 28'h0000000, 0, "R5");
        check1("R5", err_n, 1'b1);
        // R6: error, then another error one edge later restarts hold
        step(1, 0, 0, 0, 28'h0000007, 0, "R6");
        step(1, 0, 0, 0, 28'h0000005, 0, "R6");   // 0x7 odd + 0 -> error
        check1("R6", err_n, 1'b0);
        step(1, 1, 1, 0, 28'h0000000, 1, "R6");   // 0x5 even + 1 -> error again
        step(1, 1, 1, 0, 28'h0000000, 0, "R6");
        check1("R6", err_n, 1'b0);
        step(1, 1, 1, 0, 28'h0000000, 0, "R6");
        check1("R6", err_n, 1'b1);
        // R8: bad word captured just before low-power, held through and after
        step(1, 0, 1, 1, 28'h0000001, 0, "R8");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 28'h0FFFFFF, 0, "R8");
        checkw("R7", dout, 28'h0000001);
        check1("R8", err_n, 1'b0);
        step(1, 1, 1, 0, 28'h0000000, 0, "R8");
        check1("R8", err_n, 1'b0);
        step(1, 1, 1, 0, 28'h0000000, 0, "R8");
        check1("R8", err_n, 1'b1);
        // R4: word seen with no select, wrong parity next edge -> no error
        step(1, 1, 1, 0, 28'h0000001, 0, "R4");
        step(1, 1, 1, 0, 28'h0000000, 0, "R4");
        check1("R4", err_n, 1'b1);
        // R9: reset masks a low flag without an edge
        step(1, 1, 0, 0, 28'h0000001, 0, "R9");
        step(1, 1, 1, 0, 28'h0000000, 0, "R2");
        check1("R2", err_n, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check1("R9", err_n, 1'b1);
        step(0, 1, 1, 0, 28'h0000000, 0, "R9");
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            w = DATA_W'($urandom);
            step(($urandom % 200) != 0,
                 ($urandom % 10) >= 6,
                 ($urandom % 10) >= 3,
                 $urandom % 2,
                 w,
                 m_par ^ (($urandom % 10) < 3),
                 "R2");
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule